// File: doc/BRIEF.md
# Register-Paced Serial Codec Controller

This block is the master side of a four-wire serial link to an external codec or serial flash, run by a microcontroller through a small byte-wide register bus. The microcontroller sets the address length, the edge on which the far end latches data, the direction of the flash access and an optional register-select line. It then sets a start bit. The block drops the chip enable and asks for each outgoing byte by raising a write-request flag. It shifts each byte out MSB first at a quarter of the system clock rate, and on a read it raises a read-request flag once the received byte is ready.

One transfer carries one or two address bytes followed by a single data byte. The address bytes, and the data byte of a write, come one at a time through the data register. The engine waits with the serial clock parked for as long as the microcontroller takes to supply each one. On a read, the data byte is clocked out as zeros while the input line is sampled, and the start bit stays set until the microcontroller collects the result. In serial-interface mode a select line carries a programmed level during the eighth bit of every byte, which lets the far end tell a command from data.

Top module: `codec_spi_ctrl`

## Requirements
- R1: After reset, the config register (address 0x3C) reads 0xC0, the command register (0x3D) reads 0x40, and spi_cs_n is high.
- R2: Config bits 7, 6, 3 and 2 read back as written and config bits 5:4 always read 0. Command bits 6:5 read back as written while idle, command bits 4:0 always read 0, and a command write with bit 7 at 0 starts nothing.
- R3: A command write with bit 7 at 1 while idle starts a transfer. From the next cycle spi_cs_n is low, command bit 7 (busy) reads 1 and config bit 0 (write request) reads 1.
- R4: Each bit lasts DIV system cycles (4 by default) and mosi is steady for the whole bit. With command bit 6 at 1, sclk idles low and is high in the second half of each bit. With bit 6 at 0, sclk idles high and is low in the second half.
- R5: Config bit 6 selects two address bytes (1) or one (0). Each address byte, and the data byte of a write, is loaded by a write to the data register (0x3E), which clears config bit 0 and is shifted MSB first.
- R6: While config bit 0 is set, no sclk edge occurs and sclk stays at its idle level.
- R7: With command bit 5 at 1 (flash write), the transfer ends after the data byte: spi_cs_n goes high after its last bit and command bit 7 returns to 0.
- R8: With command bit 5 at 0 (flash read), the data byte is sent as zeros while spi_miso is sampled MSB first in the second half of each bit. spi_cs_n then goes high and config bit 1 (read request) is set. Reading 0x3E returns the byte and clears both config bit 1 and command bit 7. The two request flags are never set together.
- R9: With config bit 3 at 1, spi_rs equals config bit 2 during the eighth bit of every byte and is 0 otherwise. With config bit 3 at 0, spi_rs stays 0.
- R10: While busy, a command-register write is ignored entirely: neither a second start nor changed edge or direction bits take effect.
- R11: Config bit 7 has no effect on operation. Transfers run as master with it at either value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| spi_cs_n | output | 1 | Chip enable, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_rs | output | 1 | Register-select line for serial-interface mode |

## Verification
A stuck or skipped engine state shows on the bus within one cycle of the command write: the write-request flag fails to rise, or a second start disturbs the bit count. A wrong bit or byte counter changes the number of sclk edges captured between chip-enable edges. That error appears as a wrong shifted word or a misplaced select pulse by the end of the same transfer. A receive-path fault appears as a wrong byte at the first data-register read after chip enable rises. A clock-phase fault breaks the spacing of active edges, or leaves sclk off its idle level, within one bit time.

// File: rtl/codec_spi_pkg.sv
package codec_spi_pkg;

  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam logic [7:0] REG_CFG  = 8'h3C;
  localparam logic [7:0] REG_CMD  = 8'h3D;
  localparam logic [7:0] REG_DATA = 8'h3E;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_WR,
    ST_SHIFT,
    ST_WAIT_RD
  } eng_state_t;

  typedef struct packed {
    logic slave_sel;
    logic two_addr;
    logic si_mode;
    logic rs_level;
  } cfg_t;

  typedef struct packed {
    logic latch_hi;
    logic flash_wr;
  } cmd_t;

  // index of the final byte of a transfer: address bytes plus one data byte
  function automatic logic [1:0] last_byte_idx(input logic two_addr);
    return two_addr ? 2'd2 : 2'd1;
  endfunction

  // sclk level: active half shows latch_hi, idle half shows its inverse
  function automatic logic sclk_level(input logic active, input logic latch_hi);
    return active ~^ latch_hi;
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(input cfg_t c, input logic rd_req,
                                                 input logic wr_req);
    return {c.slave_sel, c.two_addr, 2'b00, c.si_mode, c.rs_level, rd_req, wr_req};
  endfunction

  function automatic logic [DATA_W-1:0] pack_cmd(input logic busy, input cmd_t m);
    return {busy, m.latch_hi, m.flash_wr, 5'b00000};
  endfunction

endpackage

// File: rtl/spi_bitclk.sv
module spi_bitclk #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic act,
  output logic bit_end
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act     = run && (cnt_q >= HALF);
  assign bit_end = run && (cnt_q == LAST);
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import codec_spi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rx_byte,
  output cfg_t              cfg,
  output cmd_t              cmd,
  output logic              start_pls,
  output logic              data_wr,
  output logic              data_rd
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(REG_CMD);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);

  logic hit_cfg, hit_cmd, hit_data;
  assign hit_cfg  = (bus_addr == A_CFG);
  assign hit_cmd  = (bus_addr == A_CMD);
  assign hit_data = (bus_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '{slave_sel: 1'b1, two_addr: 1'b1, si_mode: 1'b0, rs_level: 1'b0};
      cmd <= '{latch_hi: 1'b1, flash_wr: 1'b0};
    end else begin
      if (bus_wr && hit_cfg) begin
        cfg <= '{slave_sel: bus_wdata[7], two_addr: bus_wdata[6],
                 si_mode: bus_wdata[3], rs_level: bus_wdata[2]};
      end
      if (bus_wr && hit_cmd && !busy) begin
        cmd <= '{latch_hi: bus_wdata[6], flash_wr: bus_wdata[5]};
      end
    end
  end

  assign start_pls = bus_wr && hit_cmd && !busy && bus_wdata[7];
  assign data_wr   = bus_wr && hit_data;
  assign data_rd   = bus_rd && hit_data;

  always_comb begin
    bus_rdata = '0;
    if (hit_cfg)       bus_rdata = pack_cfg(cfg, rd_req, wr_req);
    else if (hit_cmd)  bus_rdata = pack_cmd(busy, cmd);
    else if (hit_data) bus_rdata = rx_byte;
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import codec_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              two_addr,
  input  logic              si_mode,
  input  logic              rs_level,
  input  logic              latch_hi,
  input  logic              flash_wr,
  input  logic              act,
  input  logic              bit_end,
  input  logic              miso,
  output logic              run,
  output logic              busy,
  output logic              wr_req,
  output logic              rd_req,
  output logic [DATA_W-1:0] rx_byte,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              rs
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  eng_state_t        state_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-2:0] rx_q;
  logic [CNT_W-1:0]  bit_q;
  logic [1:0]        byte_q;
  logic [1:0]        last_idx;
  logic              byte_done;
  logic              final_byte;

  assign last_idx   = last_byte_idx(two_addr);
  assign byte_done  = bit_end && (bit_q == LAST_BIT);
  assign final_byte = (byte_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      rx_q    <= '0;
      rx_byte <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_WAIT_WR;
            cs_n    <= 1'b0;
            wr_req  <= 1'b1;
            byte_q  <= '0;
          end
        end
        ST_WAIT_WR: begin
          if (data_wr) begin
            tx_q    <= wdata;
            wr_req  <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (bit_end) begin
            rx_q <= {rx_q[DATA_W-3:0], miso};
          end
          if (byte_done) begin
            bit_q <= '0;
            if (final_byte) begin
              cs_n <= 1'b1;
              if (flash_wr) begin
                state_q <= ST_IDLE;
              end else begin
                rx_byte <= {rx_q, miso};
                rd_req  <= 1'b1;
                state_q <= ST_WAIT_RD;
              end
            end else begin
              byte_q <= byte_q + 2'd1;
              if ((byte_q + 2'd1 == last_idx) && !flash_wr) begin
                tx_q <= '0;
              end else begin
                wr_req  <= 1'b1;
                state_q <= ST_WAIT_WR;
              end
            end
          end else if (bit_end) begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= tx_q << 1;
          end
        end
        ST_WAIT_RD: begin
          if (data_rd) begin
            rd_req  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run  = (state_q == ST_SHIFT);
  assign busy = (state_q != ST_IDLE);
  assign sclk = sclk_level(run && act, latch_hi);
  assign mosi = run && tx_q[DATA_W-1];
  assign rs   = (run && si_mode && bit_q == LAST_BIT) ? rs_level : 1'b0;
endmodule

// File: rtl/codec_spi_ctrl.sv
module codec_spi_ctrl
  import codec_spi_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_rs
);
  cfg_t              cfg;
  cmd_t              cmd;
  logic              start_pls, data_wr, data_rd;
  logic              busy, wr_req, rd_req, run, act, bit_end;
  logic              latch_hi, si_mode;
  logic [DATA_W-1:0] rx_byte;

  assign latch_hi = cmd.latch_hi;
  assign si_mode  = cfg.si_mode;

  spi_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .wr_req(wr_req), .rd_req(rd_req), .rx_byte(rx_byte),
    .cfg(cfg), .cmd(cmd), .start_pls(start_pls),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  spi_bitclk #(.DIV(DIV)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(run), .act(act), .bit_end(bit_end)
  );

  spi_engine u_engine (
    .clk(clk), .rst_n(rst_n), .start(start_pls),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(bus_wdata),
    .two_addr(cfg.two_addr), .si_mode(si_mode), .rs_level(cfg.rs_level),
    .latch_hi(latch_hi), .flash_wr(cmd.flash_wr),
    .act(act), .bit_end(bit_end), .miso(spi_miso),
    .run(run), .busy(busy), .wr_req(wr_req), .rd_req(rd_req),
    .rx_byte(rx_byte), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .rs(spi_rs)
  );
endmodule

// File: rtl/codec_spi_chk.sv
module codec_spi_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic rs,
  input logic busy,
  input logic wr_req,
  input logic rd_req,
  input logic run,
  input logic bit_end,
  input logic latch_hi,
  input logic si_mode,
  input logic data_wr,
  input logic data_rd
);
  a_r4_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == !latch_hi));

  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(bit_end)) |-> $stable(mosi));

  a_r5_wr_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && data_wr) |=> !wr_req);

  a_r6_stall_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (!run && sclk == !latch_hi));

  a_r3_cs_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && rd_req));

  a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && data_rd) |=> (!rd_req && !busy));

  a_r9_rs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !si_mode |-> !rs);
endmodule

bind codec_spi_ctrl codec_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .mosi(spi_mosi), .rs(spi_rs), .busy(busy), .wr_req(wr_req),
  .rd_req(rd_req), .run(run), .bit_end(bit_end), .latch_hi(latch_hi),
  .si_mode(si_mode), .data_wr(data_wr), .data_rd(data_rd)
);

// File: tb/codec_spi_ctrl_test.sv
`timescale 1ns/1ps
module codec_spi_ctrl_test;
  localparam int DIV = 4;
  localparam logic [7:0] A_CFG = 8'h3C, A_CMD = 8'h3D, A_DATA = 8'h3E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso, spi_rs;

  int checks = 0, fails = 0;
  longint cyc = 0;

  // serial monitor and model of the far end
  logic        mon_en = 1'b0;
  logic        cfg_lh = 1'b1;
  logic        prev_sclk = 1'b0;
  logic [23:0] cap = '0, rsrec = '0;
  logic [31:0] slave_word = '0;
  int          nbits = 0, per_err = 0, idle_err = 0;
  longint      last_cyc = 0;

  assign spi_miso = slave_word[31];

  always #2.5 clk = ~clk;

  codec_spi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_rs(spi_rs)
  );

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (spi_cs_n && spi_sclk !== !cfg_lh) idle_err++;
      if (!spi_cs_n && prev_sclk == !cfg_lh && spi_sclk == cfg_lh) begin
        cap   = {cap[22:0], spi_mosi};
        rsrec = {rsrec[22:0], spi_rs};
        if ((nbits % 8) != 0 && (cyc - last_cyc) != DIV) per_err++;
        last_cyc = cyc;
        nbits++;
      end
      if (prev_sclk == cfg_lh && spi_sclk == !cfg_lh) slave_word = slave_word << 1;
      prev_sclk = spi_sclk;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cfg_bit(input int b, output logic ok);
    logic [7:0] v;
    ok = 1'b0;
    for (int i = 0; i < 500 && !ok; i++) begin
      bus_read(A_CFG, v);
      ok = v[b];
    end
  endtask

  task automatic wait_cs_high(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 500 && !ok; i++) begin
      @(negedge clk);
      ok = spi_cs_n;
    end
  endtask

  task automatic t_reset_values();
    logic [7:0] v;
    chk(spi_cs_n == 1'b1, "R1 cs_n after reset", spi_cs_n, 1);
    bus_read(A_CFG, v); chk(v == 8'hC0, "R1 config reset", v, 8'hC0);
    bus_read(A_CMD, v); chk(v == 8'h40, "R1 command reset", v, 8'h40);
  endtask

  task automatic t_reg_access();
    logic [7:0] v;
    bus_write(A_CFG, 8'hFF);
    bus_read(A_CFG, v); chk(v == 8'hCC, "R2 config reserved bits", v, 8'hCC);
    bus_write(A_CFG, 8'h33);
    bus_read(A_CFG, v); chk(v == 8'h00, "R2 config clear", v, 8'h00);
    bus_write(A_CMD, 8'h7F);
    bus_read(A_CMD, v); chk(v == 8'h60, "R2 command bits, no start", v, 8'h60);
    chk(spi_cs_n == 1'b1, "R2 no start without bit7", spi_cs_n, 1);
    bus_write(A_CMD, 8'h1F);
    bus_read(A_CMD, v); chk(v == 8'h00, "R2 command clear", v, 8'h00);
    bus_write(A_CMD, 8'h40);
  endtask

  // one complete transfer; cfg7 keeps config bit 7, poke tries a restart while busy
  task automatic t_xfer(input string tag, input logic cfg7, input logic two,
                        input logic fwr, input logic lh, input logic si,
                        input logic rsl, input logic [15:0] addr,
                        input logic [7:0] wd, input logic [7:0] rx, input logic poke);
    logic [7:0]  v;
    logic        ok;
    int          nbytes, nb0;
    logic [23:0] exp_cap, exp_rs;
    nbytes = two ? 3 : 2;
    bus_write(A_CFG, {cfg7, two, 2'b00, si, rsl, 2'b00});
    slave_word = two ? {8'hA5, 8'h5A, rx, 8'h00} : {8'hA5, rx, 16'h0000};
    cap = '0; rsrec = '0; nbits = 0; per_err = 0; idle_err = 0;
    cfg_lh = lh;
    bus_write(A_CMD, {1'b1, lh, fwr, 5'b0});
    prev_sclk = !lh;
    mon_en = 1'b1;
    // R3: start took effect
    chk(spi_cs_n == 1'b0, {tag, " R3 cs_n low after start"}, spi_cs_n, 0);
    bus_read(A_CMD, v); chk(v[7] == 1'b1, {tag, " R3 busy bit"}, v[7], 1);
    bus_read(A_CFG, v); chk(v[0] == 1'b1, {tag, " R3 write request"}, v[0], 1);
    if (poke) begin
      bus_write(A_CMD, {1'b1, !lh, !fwr, 5'b0});
      bus_read(A_CMD, v);
      chk(v == {1'b1, lh, fwr, 5'b0}, {tag, " R10 command frozen while busy"}, v, {1'b1, lh, fwr, 5'b0});
      chk(nbits == 0, {tag, " R10 no restart"}, nbits, 0);
    end
    for (int b = 0; b < nbytes; b++) begin
      if (b == nbytes - 1 && !fwr) break;
      wait_cfg_bit(0, ok);
      chk(ok, {tag, " R5 write request per byte"}, ok, 1);
      nb0 = nbits;
      repeat (6) @(negedge clk);
      chk(nbits == nb0 && spi_sclk == !lh, {tag, " R6 stalled while request set"}, nbits, nb0);
      if (two && b == 0)           bus_write(A_DATA, addr[15:8]);
      else if (b == nbytes - 1)    bus_write(A_DATA, wd);
      else                         bus_write(A_DATA, addr[7:0]);
    end
    wait_cs_high(ok);
    chk(ok, {tag, " R7 cs_n returns high"}, ok, 1);
    chk(nbits == 8 * nbytes, {tag, " R5 bit count"}, nbits, 8 * nbytes);
    exp_cap = two ? {addr, (fwr ? wd : 8'h00)} : {8'h00, addr[7:0], (fwr ? wd : 8'h00)};
    chk(cap == exp_cap, {tag, " R5 shifted word MSB first"}, cap, exp_cap);
    chk(per_err == 0 && idle_err == 0, {tag, " R4 bit period and idle level"}, per_err + idle_err, 0);
    exp_rs = '0;
    for (int b = 0; b < nbytes; b++) exp_rs[8 * b] = si & rsl;
    chk(rsrec == exp_rs, {tag, " R9 select line pattern"}, rsrec, exp_rs);
    if (fwr) begin
      bus_read(A_CMD, v); chk(v[7] == 1'b0, {tag, " R7 busy cleared"}, v[7], 0);
    end else begin
      bus_read(A_CFG, v); chk(v[1:0] == 2'b10, {tag, " R8 read request"}, v[1:0], 2);
      bus_read(A_CMD, v); chk(v[7] == 1'b1, {tag, " R8 busy until collected"}, v[7], 1);
      bus_read(A_DATA, v); chk(v == rx, {tag, " R8 received byte"}, v, rx);
      bus_read(A_CFG, v); chk(v[1] == 1'b0, {tag, " R8 read request cleared"}, v[1], 0);
      bus_read(A_CMD, v); chk(v[7] == 1'b0, {tag, " R8 busy cleared"}, v[7], 0);
    end
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_values();
    t_reg_access();
    // R11: config bit 7 left at 1, transfers still run as master
    t_xfer("x1 R11", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hB32C, 8'h96, 8'h00, 1'b0);
    t_xfer("x2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0071, 8'h00, 8'hC5, 1'b1);
    t_xfer("x3 R11", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h8E41, 8'h00, 8'h3B, 1'b0);
    t_xfer("x4", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h00D9, 8'h6A, 8'h00, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule